// File: doc/BRIEF.md
# Fixed-Function Event Tally with Free-Running Timestamp

This block keeps four 48-bit counters side by side. The first is a timestamp that advances on every reference-rate tick and is never gated. The other three are fixed-function event counters. One counts retired instructions. One counts core clock enables while the core is running. One counts reference ticks while the core is running. The core counts as running when it is not halted, not held by a thermal stop-clock and not stalled for a frequency change.

The reference-cycle counter and the timestamp share the same tick. Software can therefore read both and subtract them to measure how long the core spent gated, for example the few tens of microseconds lost during each performance-state change. Each fixed counter has its own enable, synchronous clear and load strobe. The timestamp can only be written through its own load strobe. One read port registers any of the four counters in a single cycle.

Top module: `evt_tally_top`

## Requirements
- R1: After reset all four counters and `rd_data` are zero.
- R2: The timestamp (read address 0) increases by one in every cycle in which `ref_tick` is high. Halt, stop-clock, frequency stall and the enable bits have no effect on it.
- R3: `ts_ld` loads `ld_val` into the timestamp, taking priority over its increment. The `cnt_ld`, `cnt_clr` and `cnt_en` bits never change the timestamp.
- R4: The retired-instruction counter (read address 1, control bit 0) increases by one in each cycle with `retire` high while `cnt_en[0]` is set.
- R5: The core-cycle counter (read address 2, control bit 1) increases by one in each cycle with `core_tick` high while `cnt_en[1]` is set and none of `halted`, `clk_stop`, `freq_stall` is high.
- R6: The reference-cycle counter (read address 3, control bit 2) increases by one in each cycle with `ref_tick` high while `cnt_en[2]` is set and none of `halted`, `clk_stop`, `freq_stall` is high. It never advances without `ref_tick`.
- R7: A fixed counter whose enable bit is low holds its value.
- R8: `cnt_clr[i]` zeroes fixed counter i at the next edge, whatever its enable bit. Clear wins over load and over increment.
- R9: `cnt_ld[i]` loads `ld_val` into fixed counter i, taking priority over its increment.
- R10: When `rd_en` is high, `rd_data` takes, at the next edge, the value the counter at `rd_addr` held before that edge. Addresses are 0 timestamp, 1 retired, 2 core, 3 reference. When `rd_en` is low, `rd_data` holds.
- R11: Every counter wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference-rate tick enable |
| core_tick | input | 1 | Core clock enable |
| retire | input | 1 | One instruction retired this cycle |
| halted | input | 1 | Core halted |
| clk_stop | input | 1 | Thermal stop-clock active |
| freq_stall | input | 1 | Frequency-transition stall |
| cnt_en | input | 3 | Per fixed counter enable (0 retired, 1 core, 2 reference) |
| cnt_clr | input | 3 | Per fixed counter synchronous clear |
| cnt_ld | input | 3 | Per fixed counter load strobe |
| ts_ld | input | 1 | Timestamp load strobe |
| ld_val | input | 48 | Shared load value |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Counter to read |
| rd_data | output | 48 | Registered read data |

## Verification
The bench sweeps every combination of the six event inputs against every enable pattern. A design that gated the timestamp with halt, or that forgot one of the three gating conditions on the core or reference counter, drifts from the arithmetic model within a few cycles. A pseudo-random pass overlays clear, load and timestamp-load strobes. A wrong priority among clear, load and increment shows up there as an off-by-one value or a stale value. A load strobe that leaked into the timestamp is also caught in this pass. Directed steps load all ones and tick once, which exposes a counter that saturates or carries wrongly. Idle read cycles expose a read port that follows the live counter instead of holding the captured value.

// File: rtl/evt_tally_pkg.sv
package evt_tally_pkg;

  typedef enum logic [1:0] {
    EV_RETIRE = 2'd0,
    EV_CORE   = 2'd1,
    EV_REF    = 2'd2
  } evt_kind_e;

  // Map a fixed-counter index onto the event it tallies.
  function automatic evt_kind_e kind_of(input int idx);
    case (idx)
      0:       return EV_RETIRE;
      1:       return EV_CORE;
      default: return EV_REF;
    endcase
  endfunction

  // Core is running when no gating condition holds.
  function automatic logic core_running(input logic halted, input logic clk_stop,
                                        input logic freq_stall);
    return !(halted || clk_stop || freq_stall);
  endfunction

  // Raw event for a given kind, before the per-counter enable.
  function automatic logic fix_event(input evt_kind_e k, input logic retire,
                                     input logic core_tick, input logic ref_tick,
                                     input logic run);
    case (k)
      EV_RETIRE: return retire;
      EV_CORE:   return core_tick && run;
      default:   return ref_tick && run;
    endcase
  endfunction

endpackage

// File: rtl/evt_tally_cell.sv
module evt_tally_cell #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (ld)  q <= ld_val;
    else if (inc) q <= q + 1'b1;
  end
endmodule

// File: rtl/evt_tally_gate.sv
module evt_tally_gate
  import evt_tally_pkg::*;
#(
  parameter int N_FIX = 3
) (
  input  logic             ref_tick,
  input  logic             core_tick,
  input  logic             retire,
  input  logic             halted,
  input  logic             clk_stop,
  input  logic             freq_stall,
  input  logic [N_FIX-1:0] en,
  output logic             ts_inc,
  output logic             run,
  output logic [N_FIX-1:0] fix_inc
);
  assign run    = core_running(halted, clk_stop, freq_stall);
  assign ts_inc = ref_tick;

  for (genvar g = 0; g < N_FIX; g++) begin : g_evt
    localparam evt_kind_e KIND = kind_of(g);
    assign fix_inc[g] = en[g] && fix_event(KIND, retire, core_tick, ref_tick, run);
  end
endmodule

// File: rtl/evt_tally_rdport.sv
module evt_tally_rdport #(
  parameter int W  = 48,
  parameter int N  = 4,
  parameter int AW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_en,
  input  logic [AW-1:0]  rd_addr,
  input  logic [N*W-1:0] cnt_flat,
  output logic [W-1:0]   rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= cnt_flat[rd_addr*W +: W];
  end
endmodule

// File: rtl/evt_tally_top.sv
module evt_tally_top #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             core_tick,
  input  logic             retire,
  input  logic             halted,
  input  logic             clk_stop,
  input  logic             freq_stall,
  input  logic [2:0]       cnt_en,
  input  logic [2:0]       cnt_clr,
  input  logic [2:0]       cnt_ld,
  input  logic             ts_ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data
);
  localparam int N_FIX = 3;
  localparam int N_ALL = N_FIX + 1;
  localparam int AW    = $clog2(N_ALL);

  logic                   ts_inc;
  logic                   core_run;
  logic [N_FIX-1:0]       fix_inc;
  logic [CNT_W-1:0]       ts_q;
  logic [CNT_W-1:0]       fx_q [N_FIX];
  logic [N_ALL*CNT_W-1:0] cnt_flat;
  logic [CNT_W-1:0]       ret_q, cyc_q, rfc_q;

  evt_tally_gate #(.N_FIX(N_FIX)) u_gate (
    .ref_tick  (ref_tick),
    .core_tick (core_tick),
    .retire    (retire),
    .halted    (halted),
    .clk_stop  (clk_stop),
    .freq_stall(freq_stall),
    .en        (cnt_en),
    .ts_inc    (ts_inc),
    .run       (core_run),
    .fix_inc   (fix_inc)
  );

  evt_tally_cell #(.W(CNT_W)) u_ts (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (1'b0),
    .ld    (ts_ld),
    .ld_val(ld_val),
    .inc   (ts_inc),
    .q     (ts_q)
  );

  assign cnt_flat[CNT_W-1:0] = ts_q;

  for (genvar g = 0; g < N_FIX; g++) begin : g_fix
    evt_tally_cell #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr[g]),
      .ld    (cnt_ld[g]),
      .ld_val(ld_val),
      .inc   (fix_inc[g]),
      .q     (fx_q[g])
    );
    assign cnt_flat[(g+1)*CNT_W +: CNT_W] = fx_q[g];
  end

  assign ret_q = fx_q[0];
  assign cyc_q = fx_q[1];
  assign rfc_q = fx_q[2];

  evt_tally_rdport #(.W(CNT_W), .N(N_ALL), .AW(AW)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .cnt_flat(cnt_flat),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/evt_tally_chk.sv
module evt_tally_chk #(
  parameter int W = 48
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ref_tick,
  input logic         halted,
  input logic         clk_stop,
  input logic         freq_stall,
  input logic [2:0]   cnt_en,
  input logic [2:0]   cnt_clr,
  input logic [2:0]   cnt_ld,
  input logic         ts_ld,
  input logic [W-1:0] ld_val,
  input logic         rd_en,
  input logic [1:0]   rd_addr,
  input logic [W-1:0] rd_data,
  input logic [W-1:0] ts_q,
  input logic [W-1:0] ret_q,
  input logic [W-1:0] cyc_q,
  input logic [W-1:0] rfc_q
);
  logic gated;
  assign gated = halted || clk_stop || freq_stall;

  AST_TS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && !ts_ld) |=> ts_q == W'($past(ts_q) + 1'b1)); // R2
  AST_TS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ts_ld |=> ts_q == $past(ld_val)); // R3
  AST_CORE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && !cnt_clr[1] && !cnt_ld[1]) |=> $stable(cyc_q)); // R5
  AST_REF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && !cnt_clr[2] && !cnt_ld[2]) |=> $stable(rfc_q)); // R6
  AST_REF_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_tick && !cnt_clr[2] && !cnt_ld[2]) |=> $stable(rfc_q)); // R6
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en[0] && !cnt_clr[0] && !cnt_ld[0]) |=> $stable(ret_q)); // R7
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr[2] |=> rfc_q == '0); // R8
  AST_LOAD_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ld[1] && !cnt_clr[1]) |=> cyc_q == $past(ld_val)); // R9
  AST_RD_TS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 2'd0) |=> rd_data == $past(ts_q)); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R10
endmodule

bind evt_tally_top evt_tally_chk #(.W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_tick  (ref_tick),
  .halted    (halted),
  .clk_stop  (clk_stop),
  .freq_stall(freq_stall),
  .cnt_en    (cnt_en),
  .cnt_clr   (cnt_clr),
  .cnt_ld    (cnt_ld),
  .ts_ld     (ts_ld),
  .ld_val    (ld_val),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .ts_q      (ts_q),
  .ret_q     (ret_q),
  .cyc_q     (cyc_q),
  .rfc_q     (rfc_q)
);

// File: tb/sim_evt_tally_top.sv
module sim_evt_tally_top;
  localparam int W = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 0, core_tick = 0, retire = 0;
  logic halted = 0, clk_stop = 0, freq_stall = 0;
  logic [2:0] cnt_en = '0, cnt_clr = '0, cnt_ld = '0;
  logic ts_ld = 0;
  logic [W-1:0] ld_val = '0;
  logic rd_en = 0;
  logic [1:0] rd_addr = '0;
  logic [W-1:0] rd_data;

  logic [W-1:0] m [4];
  logic [W-1:0] exp_rd;
  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  evt_tally_top #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .core_tick(core_tick),
    .retire(retire), .halted(halted), .clk_stop(clk_stop), .freq_stall(freq_stall),
    .cnt_en(cnt_en), .cnt_clr(cnt_clr), .cnt_ld(cnt_ld), .ts_ld(ts_ld),
    .ld_val(ld_val), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // One clock: model the requirements, then compare the read port at the negedge.
  task automatic cyc(input string tag);
    logic run, ev;
    @(posedge clk);
    if (rd_en) exp_rd = m[rd_addr];
    if (ts_ld) m[0] = ld_val;
    else if (ref_tick) m[0] = m[0] + 1'b1;
    run = !(halted | clk_stop | freq_stall);
    for (int i = 0; i < 3; i++) begin
      ev = (i == 0) ? retire : (i == 1) ? (core_tick & run) : (ref_tick & run);
      if (cnt_clr[i]) m[i+1] = '0;
      else if (cnt_ld[i]) m[i+1] = ld_val;
      else if (cnt_en[i] && ev) m[i+1] = m[i+1] + 1'b1;
    end
    @(negedge clk);
    check(rd_en ? tag : "R10", rd_data, exp_rd);
  endtask

  function automatic string sweep_tag(input logic [1:0] a, input logic [2:0] en);
    if (a == 2'd0) return "R2";
    if (!en[a-1]) return "R7";
    return (a == 2'd1) ? "R4" : (a == 2'd2) ? "R5" : "R6";
  endfunction

  initial begin
    for (int i = 0; i < 4; i++) m[i] = '0;
    exp_rd = '0;
    repeat (3) @(negedge clk);
    check("R1", rd_data, '0);
    rst_n = 1'b1;
    // R1: read every counter with no activity
    rd_en = 1;
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      cyc("R1");
    end
    // R2 R4 R5 R6 R7: every event pattern under every enable pattern
    for (int v = 0; v < 512; v++) begin
      {cnt_en, freq_stall, clk_stop, halted, retire, core_tick, ref_tick} = 9'(v);
      rd_en = 1;
      rd_addr = 2'(v + v / 64);
      cyc(sweep_tag(rd_addr, cnt_en));
    end
    // R8 R9 R3: clears, loads and timestamp loads overlaid on traffic
    for (int v = 0; v < 600; v++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      {cnt_en, freq_stall, clk_stop, halted, retire, core_tick, ref_tick} = lfsr[8:0];
      cnt_clr = lfsr[15:13] & {3{lfsr[2:0] == 3'b000}};
      cnt_ld  = lfsr[12:10] & {3{lfsr[5:3] == 3'b001}};
      ts_ld   = (lfsr[6:0] == 7'h11);
      ld_val  = {lfsr, ~lfsr, lfsr};
      rd_en   = lfsr[9] | lfsr[4];
      rd_addr = lfsr[11:10];
      cyc("R8 R9 R3");
    end
    cnt_clr = '0; cnt_ld = '0; ts_ld = 0;
    // R3: fixed-counter strobes must not touch the timestamp
    {freq_stall, clk_stop, halted, retire, core_tick, ref_tick} = '0;
    cnt_ld = 3'b111; cnt_clr = 3'b111; ld_val = 48'h123456789ABC; rd_en = 0;
    cyc("R3");
    cnt_ld = '0; cnt_clr = '0; rd_en = 1; rd_addr = 2'd0;
    cyc("R3");
    cyc("R3");
    // R11: all ones then one tick wraps to zero
    ld_val = '1; ts_ld = 1; cnt_ld = 3'b111; cnt_en = 3'b111;
    cyc("R11");
    ts_ld = 0; cnt_ld = '0;
    ref_tick = 1; core_tick = 1; retire = 1;
    cyc("R11");
    ref_tick = 0; core_tick = 0; retire = 0;
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      cyc("R11");
    end
    // R10: read port holds while idle
    rd_en = 0; ref_tick = 1;
    repeat (4) cyc("R10");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog R1: actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule